// File: doc/BRIEF.md
# Fused-Pair Issue Queue Slice

This block is a small slice of an out-of-order issue queue. Each slot can hold either an ordinary single-cycle instruction or a fused pair of two dependent single-cycle instructions. A fused pair shares one slot, one set of external source tags and one destination tag. The slot wakes up from result-tag broadcasts and raises a request to an outside select stage once every external source it waits on is ready. A fused slot issues as one unit.

From the scheduler's point of view, a fused slot is a two-cycle operation that cannot be pipelined. After its grant the slice holds all requests low for one cycle, and it broadcasts the pair's tag one cycle late, so that dependents issue two cycles after the pair. A single slot broadcasts in its grant cycle, so its dependents can issue in the very next cycle. A two-slot payload store per entry then sends the first and second original instructions on consecutive cycles. The same broadcast is fed back into the slice's own wakeup logic and also leaves the block, for other slices.

When a fused slot is allocated, any source that names the pair's own destination tag is the second instruction reading the first one's result. That source is marked internal and never waited on. The parameter `WIRED_OR` selects three external sources per slot (1) or two (0).

Top module: `mop_issue_slice`

## Requirements
- R1: After reset no request, no tag broadcast and no payload beat is presented.
- R2: A valid slot drives its bit of `req` high only when every external source it uses is ready. A broadcast on `ext_bc_valid/ext_bc_tag` in cycle t that readies the last missing source makes `req` high in cycle t+1.
- R3: Each issue produces exactly one broadcast on `bc_valid/bc_tag` carrying the slot's destination tag. A single slot broadcasts in its grant cycle. A fused slot broadcasts in the cycle after its grant, and never in its grant cycle.
- R4: A slot waiting on a single slot's tag can request in the cycle after that producer's grant. A slot waiting on a fused slot's tag requests no earlier than two cycles after the producer's grant.
- R5: A grant in cycle g gives a payload beat in g+1 with `pay_tail`=0 and the first instruction's data. For a fused slot, a second beat follows in g+2 with `pay_tail`=1 and the second instruction's data. For a single slot there is no beat in g+2.
- R6: In the cycle after a fused grant, all bits of `req` are low, even for slots that are ready.
- R7: With `WIRED_OR`=1, all three source slots (bit 0, 1, 2 of `alloc_src_used`) hold a slot back until ready.
- R8: In a fused slot, a used source whose tag equals the slot's destination tag is internal and does not hold the slot back.
- R9: A grant clears the slot, so it cannot request or issue again. A grant to a slot that is not requesting produces no broadcast and no payload beat, and leaves that slot waiting.
- R10: A source whose tag is on the external broadcast in the same cycle as its allocation is captured as ready.
- R11: A source whose `alloc_src_used` bit is 0 is never waited on, whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Write a new slot this cycle |
| alloc_idx | input | IDX_W | Slot to write |
| alloc_fused | input | 1 | Slot holds a fused pair |
| alloc_src_used | input | 3 | Source slot present (bit s = source s) |
| alloc_src_rdy | input | 3 | Source already ready at allocation |
| alloc_src_tag | input | 3*TAG_W | Source tags, source s at bits s*TAG_W upward |
| alloc_dst_tag | input | TAG_W | Destination / scheduling tag |
| alloc_head_pay | input | PAY_W | First instruction payload |
| alloc_tail_pay | input | PAY_W | Second instruction payload (fused only) |
| ext_bc_valid | input | 1 | External result-tag broadcast valid |
| ext_bc_tag | input | TAG_W | External broadcast tag |
| req | output | NENT | Per-slot issue request |
| grant_en | input | 1 | Select stage grants a slot |
| grant_idx | input | IDX_W | Granted slot |
| bc_valid | output | 1 | Own destination-tag broadcast valid |
| bc_tag | output | TAG_W | Own broadcast tag |
| pay_valid | output | 1 | Payload beat valid |
| pay_tail | output | 1 | Beat is the second instruction of a pair |
| pay_data | output | PAY_W | Payload beat data |

## Verification
The assertions take three things for granted about the inputs. Allocation only targets a free slot. A slot is never allocated and granted in the same cycle. `grant_idx` stays below `NENT`. The stimulus keeps to this by working on one tracked slot at a time, granting it before it is reused, and drawing indices only from the slice's range. Grants to slots that are not requesting are allowed, and the bench issues them on purpose to check that they are ignored. External tags are drawn from a range disjoint from destination tags, so self-broadcasts never wake a source by accident.

// File: rtl/mopq_pkg.sv
package mopq_pkg;

    parameter int TAG_W   = 6;
    parameter int PAY_W   = 16;
    parameter int MAX_SRC = 3;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [PAY_W-1:0] pay_t;

    // One source operand slot of an entry
    typedef struct packed {
        logic used;
        logic internal;
        logic rdy;
        tag_t tag;
    } src_t;

    // Sequencer phase: idle, or emitting the second half of a pair
    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_TAIL = 1'b1
    } seq_ph_t;

    function automatic logic tag_hit(input logic v, input tag_t a, input tag_t b);
        return v && (a == b);
    endfunction

    function automatic logic src_ok(input src_t s);
        return !s.used || s.internal || s.rdy;
    endfunction

endpackage

// File: rtl/mopq_entry.sv
module mopq_entry
    import mopq_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc_we,
    input  logic                     alloc_fused,
    input  logic [MAX_SRC-1:0]       alloc_used,
    input  logic [MAX_SRC-1:0]       alloc_rdy,
    input  tag_t [MAX_SRC-1:0]       alloc_tag,
    input  tag_t                     alloc_dst,
    input  logic                     ext_v,
    input  tag_t                     ext_tag,
    input  logic                     self_v,
    input  tag_t                     self_tag,
    input  logic                     clear,
    output logic                     valid_o,
    output logic                     fused_o,
    output tag_t                     dst_o,
    output logic                     ready_o
);

    logic               valid_q;
    logic               fused_q;
    tag_t               dst_q;
    src_t               src_q [MAX_SRC];
    logic [MAX_SRC-1:0] ok_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            fused_q <= 1'b0;
            dst_q   <= '0;
        end else if (alloc_we) begin
            valid_q <= 1'b1;
            fused_q <= alloc_fused;
            dst_q   <= alloc_dst;
        end else if (clear) begin
            valid_q <= 1'b0;
        end
    end

    for (genvar s = 0; s < MAX_SRC; s++) begin : g_src
        if (s < NSRC) begin : g_live
            logic hit_new;
            logic hit_old;
            assign hit_new = tag_hit(ext_v, ext_tag, alloc_tag[s])
                           | tag_hit(self_v, self_tag, alloc_tag[s]);
            assign hit_old = tag_hit(ext_v, ext_tag, src_q[s].tag)
                           | tag_hit(self_v, self_tag, src_q[s].tag);

            always_ff @(posedge clk) begin
                if (rst) begin
                    src_q[s] <= '0;
                end else if (alloc_we) begin
                    src_q[s].used     <= alloc_used[s];
                    src_q[s].internal <= alloc_fused && alloc_used[s]
                                         && (alloc_tag[s] == alloc_dst);
                    src_q[s].rdy      <= alloc_rdy[s] | hit_new;
                    src_q[s].tag      <= alloc_tag[s];
                end else if (hit_old) begin
                    src_q[s].rdy <= 1'b1;
                end
            end
        end else begin : g_absent
            assign src_q[s] = '0;
        end
        assign ok_vec[s] = src_ok(src_q[s]);
    end

    assign valid_o = valid_q;
    assign fused_o = fused_q;
    assign dst_o   = dst_q;
    assign ready_o = valid_q && (&ok_vec);

endmodule

// File: rtl/mopq_payload.sv
module mopq_payload
    import mopq_pkg::*;
#(
    parameter int NENT  = 4,
    localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  pay_t             w_head,
    input  pay_t             w_tail,
    input  logic [IDX_W-1:0] ridx,
    output pay_t             r_head,
    output pay_t             r_tail
);

    pay_t slot_hd [NENT];
    pay_t slot_tl [NENT];

    for (genvar e = 0; e < NENT; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(e))) begin
                slot_hd[e] <= w_head;
                slot_tl[e] <= w_tail;
            end
        end
    end

    always_comb begin
        r_head = '0;
        r_tail = '0;
        for (int e = 0; e < NENT; e++) begin
            if (ridx == IDX_W'(e)) begin
                r_head = slot_hd[e];
                r_tail = slot_tl[e];
            end
        end
    end

endmodule

// File: rtl/mopq_seq.sv
module mopq_seq
    import mopq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic grant_fire,
    input  logic g_fused,
    input  tag_t g_dst,
    input  pay_t g_head,
    input  pay_t g_tail,
    output logic busy_o,
    output logic bc_valid,
    output tag_t bc_tag,
    output logic pay_valid,
    output logic pay_tail,
    output pay_t pay_data
);

    seq_ph_t ph_q;
    pay_t    tail_q;
    tag_t    dst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= SQ_IDLE;
            tail_q    <= '0;
            dst_q     <= '0;
            pay_valid <= 1'b0;
            pay_tail  <= 1'b0;
            pay_data  <= '0;
        end else begin
            pay_valid <= grant_fire || (ph_q == SQ_TAIL);
            pay_tail  <= !grant_fire && (ph_q == SQ_TAIL);
            pay_data  <= grant_fire ? g_head : tail_q;
            ph_q      <= (grant_fire && g_fused) ? SQ_TAIL : SQ_IDLE;
            if (grant_fire) begin
                tail_q <= g_tail;
                dst_q  <= g_dst;
            end
        end
    end

    assign busy_o   = (ph_q == SQ_TAIL);
    assign bc_valid = (grant_fire && !g_fused) || (ph_q == SQ_TAIL);
    assign bc_tag   = (ph_q == SQ_TAIL) ? dst_q : g_dst;

endmodule

// File: rtl/mop_issue_slice.sv
module mop_issue_slice
    import mopq_pkg::*;
#(
    parameter int NENT     = 4,
    parameter bit WIRED_OR = 1'b1,
    localparam int IDX_W   = (NENT > 1) ? $clog2(NENT) : 1,
    localparam int NSRC    = WIRED_OR ? 3 : 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc_en,
    input  logic [IDX_W-1:0]         alloc_idx,
    input  logic                     alloc_fused,
    input  logic [MAX_SRC-1:0]       alloc_src_used,
    input  logic [MAX_SRC-1:0]       alloc_src_rdy,
    input  logic [MAX_SRC*TAG_W-1:0] alloc_src_tag,
    input  logic [TAG_W-1:0]         alloc_dst_tag,
    input  logic [PAY_W-1:0]         alloc_head_pay,
    input  logic [PAY_W-1:0]         alloc_tail_pay,
    input  logic                     ext_bc_valid,
    input  logic [TAG_W-1:0]         ext_bc_tag,
    output logic [NENT-1:0]          req,
    input  logic                     grant_en,
    input  logic [IDX_W-1:0]         grant_idx,
    output logic                     bc_valid,
    output logic [TAG_W-1:0]         bc_tag,
    output logic                     pay_valid,
    output logic                     pay_tail,
    output logic [PAY_W-1:0]         pay_data
);

    tag_t [MAX_SRC-1:0] src_tags;
    logic [NENT-1:0]    ent_valid;
    logic [NENT-1:0]    ent_fused;
    logic [NENT-1:0]    ent_ready;
    tag_t               ent_dst [NENT];
    logic               busy;
    logic               grant_fire;
    logic               g_fused;
    tag_t               g_dst;
    pay_t               g_head;
    pay_t               g_tail;

    for (genvar s = 0; s < MAX_SRC; s++) begin : g_tagsplit
        assign src_tags[s] = alloc_src_tag[s*TAG_W +: TAG_W];
    end

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        logic we_e;
        logic clr_e;
        assign we_e  = alloc_en && (alloc_idx == IDX_W'(e));
        assign clr_e = grant_fire && (grant_idx == IDX_W'(e));

        mopq_entry #(.NSRC(NSRC)) u_ent (
            .clk         (clk),
            .rst         (rst),
            .alloc_we    (we_e),
            .alloc_fused (alloc_fused),
            .alloc_used  (alloc_src_used),
            .alloc_rdy   (alloc_src_rdy),
            .alloc_tag   (src_tags),
            .alloc_dst   (alloc_dst_tag),
            .ext_v       (ext_bc_valid),
            .ext_tag     (ext_bc_tag),
            .self_v      (bc_valid),
            .self_tag    (bc_tag),
            .clear       (clr_e),
            .valid_o     (ent_valid[e]),
            .fused_o     (ent_fused[e]),
            .dst_o       (ent_dst[e]),
            .ready_o     (ent_ready[e])
        );

        assign req[e] = ent_ready[e] && !busy;
    end

    always_comb begin
        grant_fire = 1'b0;
        g_fused    = 1'b0;
        g_dst      = '0;
        for (int e = 0; e < NENT; e++) begin
            if (grant_idx == IDX_W'(e)) begin
                grant_fire = grant_en && req[e];
                g_fused    = ent_fused[e];
                g_dst      = ent_dst[e];
            end
        end
    end

    mopq_payload #(.NENT(NENT)) u_pay (
        .clk    (clk),
        .we     (alloc_en),
        .widx   (alloc_idx),
        .w_head (alloc_head_pay),
        .w_tail (alloc_tail_pay),
        .ridx   (grant_idx),
        .r_head (g_head),
        .r_tail (g_tail)
    );

    mopq_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .grant_fire (grant_fire),
        .g_fused    (g_fused),
        .g_dst      (g_dst),
        .g_head     (g_head),
        .g_tail     (g_tail),
        .busy_o     (busy),
        .bc_valid   (bc_valid),
        .bc_tag     (bc_tag),
        .pay_valid  (pay_valid),
        .pay_tail   (pay_tail),
        .pay_data   (pay_data)
    );

endmodule

// File: rtl/mopq_chk.sv
module mopq_chk
    import mopq_pkg::*;
#(
    parameter int NENT  = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             grant_fire,
    input logic             g_fused,
    input tag_t             g_dst,
    input logic [IDX_W-1:0] grant_idx,
    input logic             alloc_en,
    input logic [IDX_W-1:0] alloc_idx,
    input logic [NENT-1:0]  req,
    input logic             bc_valid,
    input tag_t             bc_tag,
    input logic             pay_valid,
    input logic             pay_tail
);

    // R6
    fused_hold_chk: assert property (@(posedge clk) disable iff (rst)
        grant_fire && g_fused |=> req == '0);

    // R3
    fused_bc_chk: assert property (@(posedge clk) disable iff (rst)
        grant_fire && g_fused |=> bc_valid && bc_tag == $past(g_dst));

    // R3
    fused_bc_once_chk: assert property (@(posedge clk) disable iff (rst)
        grant_fire && g_fused |-> ##2 (!bc_valid || grant_fire));

    // R3
    single_bc_once_chk: assert property (@(posedge clk) disable iff (rst)
        grant_fire && !g_fused |=> (!bc_valid || grant_fire));

    // R5
    head_beat_chk: assert property (@(posedge clk) disable iff (rst)
        grant_fire |=> pay_valid && !pay_tail);

    // R5
    tail_beat_chk: assert property (@(posedge clk) disable iff (rst)
        grant_fire && g_fused |-> ##2 (pay_valid && pay_tail));

    // R9
    freed_slot_chk: assert property (@(posedge clk) disable iff (rst)
        grant_fire && !(alloc_en && alloc_idx == grant_idx)
        |=> !req[$past(grant_idx)]);

    // R9
    no_stray_beat_chk: assert property (@(posedge clk) disable iff (rst)
        pay_valid |-> $past(grant_fire) || (pay_tail && $past(grant_fire, 2)));

endmodule

bind mop_issue_slice mopq_chk #(.NENT(NENT), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .grant_fire (grant_fire),
    .g_fused    (g_fused),
    .g_dst      (g_dst),
    .grant_idx  (grant_idx),
    .alloc_en   (alloc_en),
    .alloc_idx  (alloc_idx),
    .req        (req),
    .bc_valid   (bc_valid),
    .bc_tag     (bc_tag),
    .pay_valid  (pay_valid),
    .pay_tail   (pay_tail)
);

// File: tb/tb_mop_issue_slice.sv
module tb_mop_issue_slice;
    import mopq_pkg::*;

    localparam int NENT  = 4;
    localparam int IDX_W = 2;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     alloc_en = 1'b0;
    logic [IDX_W-1:0]         alloc_idx = '0;
    logic                     alloc_fused = 1'b0;
    logic [MAX_SRC-1:0]       alloc_src_used = '0;
    logic [MAX_SRC-1:0]       alloc_src_rdy = '0;
    logic [MAX_SRC*TAG_W-1:0] alloc_src_tag = '0;
    logic [TAG_W-1:0]         alloc_dst_tag = '0;
    logic [PAY_W-1:0]         alloc_head_pay = '0;
    logic [PAY_W-1:0]         alloc_tail_pay = '0;
    logic                     ext_bc_valid = 1'b0;
    logic [TAG_W-1:0]         ext_bc_tag = '0;
    logic [NENT-1:0]          req;
    logic                     grant_en = 1'b0;
    logic [IDX_W-1:0]         grant_idx = '0;
    logic                     bc_valid;
    logic [TAG_W-1:0]         bc_tag;
    logic                     pay_valid;
    logic                     pay_tail;
    logic [PAY_W-1:0]         pay_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    mop_issue_slice #(.NENT(NENT), .WIRED_OR(1'b1)) dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Advance to the next negedge and release all pulsed inputs
    task automatic cyc();
        @(negedge clk);
        alloc_en     = 1'b0;
        grant_en     = 1'b0;
        ext_bc_valid = 1'b0;
    endtask

    task automatic settle();
        #1;
    endtask

    function automatic logic [MAX_SRC*TAG_W-1:0] pack3(input tag_t t0, input tag_t t1, input tag_t t2);
        return {t2, t1, t0};
    endfunction

    task automatic do_alloc(input int idx, input bit fz, input logic [2:0] used,
                            input logic [2:0] rdy, input logic [MAX_SRC*TAG_W-1:0] tags,
                            input tag_t dst, input pay_t hd, input pay_t tl);
        alloc_en       = 1'b1;
        alloc_idx      = IDX_W'(idx);
        alloc_fused    = fz;
        alloc_src_used = used;
        alloc_src_rdy  = rdy;
        alloc_src_tag  = tags;
        alloc_dst_tag  = dst;
        alloc_head_pay = hd;
        alloc_tail_pay = tl;
    endtask

    task automatic do_grant(input int idx);
        grant_en  = 1'b1;
        grant_idx = IDX_W'(idx);
    endtask

    task automatic ext_bc(input tag_t t);
        ext_bc_valid = 1'b1;
        ext_bc_tag   = t;
    endtask

    // Bench model: expected request given a pending-source mask
    function automatic bit exp_req(input logic [2:0] pend);
        return pend == 3'b000;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) cyc();
        rst = 1'b0;
        cyc(); settle();
        // R1 reset state
        chk(req == '0, "R1 req", req, 0);
        chk(bc_valid == 1'b0, "R1 bc_valid", bc_valid, 0);
        chk(pay_valid == 1'b0, "R1 pay_valid", pay_valid, 0);

        // ---- R2 / R11: one source waits, unused source ignored
        do_alloc(0, 0, 3'b011, 3'b001, pack3(6'd20, 6'd21, 6'd22), 6'd3, 16'hA001, 16'h0);
        cyc(); settle();
        chk(req[0] == 1'b0, "R2 waiting", req[0], 0);
        ext_bc(6'd21);
        cyc(); settle();
        chk(req[0] == 1'b1, "R2 woken next cycle", req[0], 1);
        chk(req[0] == 1'b1, "R11 unused src2 ignored", req[0], 1);
        do_grant(0); settle();
        chk(bc_valid && bc_tag == 6'd3, "R3 single bc in grant cycle", {bc_valid, bc_tag}, {1'b1, 6'd3});
        cyc(); settle();
        chk(pay_valid && !pay_tail && pay_data == 16'hA001, "R5 single head beat", {pay_valid, pay_tail, pay_data}, {2'b10, 16'hA001});
        chk(bc_valid == 1'b0, "R3 single bc once", bc_valid, 0);
        chk(req[0] == 1'b0, "R9 slot freed", req[0], 0);
        cyc(); settle();
        chk(pay_valid == 1'b0, "R5 single no second beat", pay_valid, 0);

        // ---- R7: third source holds the slot
        do_alloc(1, 0, 3'b111, 3'b011, pack3(6'd24, 6'd25, 6'd26), 6'd4, 16'hB001, 16'h0);
        cyc(); settle();
        chk(req[1] == 1'b0, "R7 src2 pending", req[1], 0);
        cyc(); settle();
        chk(req[1] == 1'b0, "R7 src2 still pending", req[1], 0);
        ext_bc(6'd26);
        cyc(); settle();
        chk(req[1] == 1'b1, "R7 src2 woken", req[1], 1);
        do_grant(1);
        cyc(); cyc();

        // ---- R8 / R6 / R5 / R4: fused pair with internal source
        do_alloc(0, 0, 3'b000, 3'b000, pack3(6'd0, 6'd0, 6'd0), 6'd5, 16'hC000, 16'h0);
        cyc();
        do_alloc(3, 0, 3'b001, 3'b000, pack3(6'd10, 6'd0, 6'd0), 6'd6, 16'hC003, 16'h0);
        cyc();
        do_alloc(2, 1, 3'b011, 3'b010, pack3(6'd10, 6'd30, 6'd0), 6'd10, 16'hC021, 16'hC022);
        cyc(); settle();
        chk(req[2] == 1'b1, "R8 internal src not waited", req[2], 1);
        chk(req[3] == 1'b0, "R4 consumer waits", req[3], 0);
        do_grant(2); settle();
        chk(bc_valid == 1'b0, "R3 fused no bc in grant cycle", bc_valid, 0);
        cyc(); settle();
        chk(pay_valid && !pay_tail && pay_data == 16'hC021, "R5 fused head beat", {pay_valid, pay_tail, pay_data}, {2'b10, 16'hC021});
        chk(bc_valid && bc_tag == 6'd10, "R3 fused bc one late", {bc_valid, bc_tag}, {1'b1, 6'd10});
        chk(req == '0, "R6 requests held", req, 0);
        chk(req[3] == 1'b0, "R4 fused dependent not at g+1", req[3], 0);
        cyc(); settle();
        chk(pay_valid && pay_tail && pay_data == 16'hC022, "R5 fused tail beat", {pay_valid, pay_tail, pay_data}, {2'b11, 16'hC022});
        chk(bc_valid == 1'b0, "R3 fused bc once", bc_valid, 0);
        chk(req[3] == 1'b1, "R4 fused dependent at g+2", req[3], 1);
        chk(req[0] == 1'b1, "R6 hold released", req[0], 1);
        do_grant(3);
        cyc(); do_grant(0);
        cyc(); cyc();

        // ---- R4: dependent of a single slot
        do_alloc(1, 0, 3'b000, 3'b000, pack3(6'd0, 6'd0, 6'd0), 6'd11, 16'hD001, 16'h0);
        cyc();
        do_alloc(2, 0, 3'b001, 3'b000, pack3(6'd11, 6'd0, 6'd0), 6'd12, 16'hD002, 16'h0);
        cyc(); settle();
        do_grant(1);
        cyc(); settle();
        chk(req[2] == 1'b1, "R4 single dependent at g+1", req[2], 1);
        do_grant(2);
        cyc(); cyc();

        // ---- R10: capture at allocation
        do_alloc(0, 0, 3'b001, 3'b000, pack3(6'd40, 6'd0, 6'd0), 6'd13, 16'hE000, 16'h0);
        ext_bc(6'd40);
        cyc(); settle();
        chk(req[0] == 1'b1, "R10 same-cycle wake captured", req[0], 1);
        do_grant(0);
        cyc(); cyc();

        // ---- R9: grant to a non-requesting slot is ignored
        do_alloc(1, 1, 3'b001, 3'b000, pack3(6'd44, 6'd0, 6'd0), 6'd14, 16'hF001, 16'hF002);
        cyc(); settle();
        do_grant(1); settle();
        chk(bc_valid == 1'b0, "R9 ignored grant no bc", bc_valid, 0);
        cyc(); settle();
        chk(pay_valid == 1'b0, "R9 ignored grant no beat", pay_valid, 0);
        ext_bc(6'd44);
        cyc(); settle();
        chk(req[1] == 1'b1, "R9 slot kept after ignored grant", req[1], 1);
        do_grant(1);
        cyc(); cyc(); cyc();

        // ---- Random: R2, R3, R5, R8 against the bench model
        for (int it = 0; it < 300; it++) begin
            int         idx;
            bit         fz;
            tag_t       dst;
            logic [2:0] used, rdy, pend;
            tag_t       tg [3];
            pay_t       hd, tl;
            idx  = $urandom_range(0, NENT - 1);
            fz   = 1'($urandom_range(0, 1));
            dst  = tag_t'($urandom_range(0, 15));
            used = 3'($urandom_range(0, 7));
            rdy  = 3'($urandom_range(0, 7));
            hd   = pay_t'($urandom);
            tl   = pay_t'($urandom);
            for (int s = 0; s < 3; s++) begin
                tg[s] = tag_t'($urandom_range(16, 63));
                if (fz && $urandom_range(0, 3) == 0) tg[s] = dst;
                pend[s] = used[s] && !rdy[s] && !(fz && tg[s] == dst);
            end
            do_alloc(idx, fz, used, rdy, pack3(tg[0], tg[1], tg[2]), dst, hd, tl);
            for (int step = 0; step < 4; step++) begin
                cyc(); settle();
                chk(req[idx] == exp_req(pend), "R2 random wakeup", req[idx], exp_req(pend));
                if (exp_req(pend)) break;
                for (int s = 0; s < 3; s++) begin
                    if (pend[s]) begin
                        tag_t t;
                        t = tg[s];
                        ext_bc(t);
                        for (int u = 0; u < 3; u++)
                            if (pend[u] && tg[u] == t) pend[u] = 1'b0;
                        break;
                    end
                end
            end
            do_grant(idx); settle();
            chk(bc_valid == !fz, "R3 random grant-cycle bc", bc_valid, !fz);
            if (!fz) chk(bc_tag == dst, "R3 random single tag", bc_tag, dst);
            cyc(); settle();
            chk(pay_valid && !pay_tail && pay_data == hd, "R5 random head", {pay_valid, pay_tail, pay_data}, {2'b10, hd});
            chk(bc_valid == fz, "R3 random late bc", bc_valid, fz);
            if (fz) chk(bc_tag == dst && req == '0, "R6 random hold", {bc_tag, req}, {dst, 4'b0});
            cyc(); settle();
            if (fz) chk(pay_valid && pay_tail && pay_data == tl, "R5 random tail", {pay_valid, pay_tail, pay_data}, {2'b11, tl});
            else    chk(pay_valid == 1'b0, "R5 random no tail", pay_valid, 0);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule